// File: doc/BRIEF.md
# Serial Port Status and Interrupt Word

This block keeps the status word of a synchronous serial port that moves data through a transmit FIFO and a receive FIFO. Each clock it takes in the live occupancy of both FIFOs, the programmed thresholds, the port enable and busy state, and a set of one-cycle event strobes. From these it builds a 32-bit status word. The word carries live level fields, service requests and FIFO flags, along with sticky event flags that software clears by writing 1 to them.

The status word is always visible on an output bus. A write strobe with a data word is the only way to change the block's state, and it can only clear sticky flags. A single interrupt line is the OR of the event flags and the two service requests, with each source gated by its own enable bit. The FIFOs, the shifter and the DMA engine sit outside this block and only send it strobes and counts.

Every output is registered. Inputs sampled at a rising clock edge show up on `stat_word` and `irq` right after that same edge.

Top module: `sport_stat_irq`

## Requirements
- R1: While `rst` is high, and right after it, `stat_word` equals 0x0000F004 and `irq` is 0.
- R2: Bits 31:25, 22, 17:16 and 1:0 always read 0. Writing 1 to them changes nothing.
- R3: Bit 23 becomes 1 when `fsync` is high while `bit_cnt` is not zero. `fsync` with `bit_cnt` equal to zero leaves it unchanged.
- R4: Bit 21 becomes 1 when `tx_pop` is high while `tx_lvl` is 0. A pop from a non-empty FIFO leaves it unchanged.
- R5: Bit 7 becomes 1 when `rx_push` is high while `rx_lvl` equals DEPTH. A push into a FIFO that is not full leaves it unchanged.
- R6: The strobes `frm_match`, `dma_eoc`, `rx_tmo` and `trail_evt` each set a sticky bit: 24, 20, 19 and 18, in that order.
- R7: A sticky bit (24, 23, 21, 20, 19, 18, 7) keeps its value until a write has 1 in its position. Writing 0 leaves it as it is. When a set event and a clearing write reach the same bit in the same cycle, the bit ends up 1.
- R8: Bits 15:12 show the low 4 bits of (`rx_lvl` − 1), so an empty RX FIFO reads 0xF. Bits 11:8 show the low 4 bits of `tx_lvl`.
- R9: Bit 6 is 1 when `port_en` is high and `rx_lvl` > `rx_thr`. Otherwise it is 0.
- R10: Bit 5 is 1 when `port_en` is high and `tx_lvl` ≤ `tx_thr` + 1. Otherwise it is 0.
- R11: Bit 4 follows `port_busy`. Bit 3 is 1 when `rx_lvl` is not 0. Bit 2 is 1 when `tx_lvl` is below DEPTH.
- R12: `irq` is 1 when at least one enabled source is set in the status word shown in the same cycle. The enable bits map to sources as follows: `irq_en[0]` bit 7, [1] bit 18, [2] bit 19, [3] bit 20, [4] bit 21, [5] bit 23, [6] bit 24, [7] bit 6, [8] bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_en | input | 1 | Serial port enabled |
| port_busy | input | 1 | A frame is in progress |
| tx_lvl | input | LVL_W | Entries in the transmit FIFO |
| rx_lvl | input | LVL_W | Entries in the receive FIFO |
| tx_thr | input | LVL_W | Transmit service threshold |
| rx_thr | input | LVL_W | Receive service threshold |
| tx_pop | input | 1 | Shifter pops the transmit FIFO |
| rx_push | input | 1 | Shifter pushes into the receive FIFO |
| fsync | input | 1 | Frame sync asserted |
| bit_cnt | input | BCNT_W | Serial bit counter value |
| dma_eoc | input | 1 | DMA end-of-chain strobe |
| rx_tmo | input | 1 | Receive timeout strobe |
| trail_evt | input | 1 | Trailing byte strobe |
| frm_match | input | 1 | Frame count reached its threshold |
| irq_en | input | 9 | Per-source interrupt enables |
| wr_en | input | 1 | Write strobe for clearing sticky flags |
| wr_data | input | 32 | Write data; each 1 clears that sticky bit |
| stat_word | output | 32 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
A sticky flag that is lost, set at the wrong time, or cleared by a stray write changes its bit in `stat_word` in the cycle right after the edge that caused it. It also changes `irq` when that source is enabled. The live fields have no memory, so a wrong encoding shows up in the first cycle that presents the level concerned. This is why both FIFOs are driven to their empty, full and off-by-one levels. The set-versus-clear race and the writes of zero only show up in the cycle after that exact pairing, so each of these cases is set up directly rather than left to random stimulus.

// File: rtl/sport_stat_pkg.sv
package sport_stat_pkg;

  localparam int NUM_STK = 7;
  localparam int NUM_IRQ = 9;

  // bit position of each sticky flag in the status word
  function automatic int stk_pos(input int idx);
    case (idx)
      0:       return 7;
      1:       return 18;
      2:       return 19;
      3:       return 20;
      4:       return 21;
      5:       return 23;
      default: return 24;
    endcase
  endfunction

  localparam logic [31:0] RSVD_MASK = 32'hFE43_0003;
  localparam logic [31:0] RST_WORD  = 32'h0000_F004;

  localparam int POS_RFS = 6;
  localparam int POS_TFS = 5;

endpackage

// File: rtl/sport_evt_qual.sv
module sport_evt_qual
  import sport_stat_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int LVL_W  = 6,
  parameter int BCNT_W = 5
) (
  input  logic [LVL_W-1:0]   tx_lvl,
  input  logic [LVL_W-1:0]   rx_lvl,
  input  logic               tx_pop,
  input  logic               rx_push,
  input  logic               fsync,
  input  logic [BCNT_W-1:0]  bit_cnt,
  input  logic               dma_eoc,
  input  logic               rx_tmo,
  input  logic               trail_evt,
  input  logic               frm_match,
  output logic [NUM_STK-1:0] ev_set
);

  localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);

  always_comb begin
    ev_set    = '0;
    ev_set[0] = rx_push && (rx_lvl >= FULL_L);   // overrun
    ev_set[1] = trail_evt;
    ev_set[2] = rx_tmo;
    ev_set[3] = dma_eoc;
    ev_set[4] = tx_pop && (tx_lvl == '0);        // underrun
    ev_set[5] = fsync && (bit_cnt != '0);        // bit count error
    ev_set[6] = frm_match;
  end

endmodule

// File: rtl/sport_sticky_bank.sv
module sport_sticky_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_q[i]);                                   // R7
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!set_i[i] && !clr_i[i]) |=> $stable(flag_q[i]));          // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]);                   // R7
  end

endmodule

// File: rtl/sport_level_view.sv
module sport_level_view #(
  parameter int DEPTH = 32,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_en,
  input  logic             port_busy,
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic [LVL_W-1:0] rx_lvl,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic [LVL_W-1:0] rx_thr,
  output logic             rfs_d,
  output logic             tfs_d,
  output logic [3:0]       rfl_q,
  output logic [3:0]       tfl_q,
  output logic             rfs_q,
  output logic             tfs_q,
  output logic             bsy_q,
  output logic             rne_q,
  output logic             tnf_q
);

  localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);

  logic [LVL_W-1:0] rx_m1;
  logic [LVL_W:0]   tx_lim;

  always_comb begin
    rx_m1  = rx_lvl - LVL_W'(1);
    tx_lim = {1'b0, tx_thr} + (LVL_W+1)'(1);
    rfs_d  = port_en && (rx_lvl > rx_thr);
    tfs_d  = port_en && ({1'b0, tx_lvl} <= tx_lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rfl_q <= 4'hF;
      tfl_q <= 4'h0;
      rfs_q <= 1'b0;
      tfs_q <= 1'b0;
      bsy_q <= 1'b0;
      rne_q <= 1'b0;
      tnf_q <= 1'b1;
    end else begin
      rfl_q <= rx_m1[3:0];
      tfl_q <= tx_lvl[3:0];
      rfs_q <= rfs_d;
      tfs_q <= tfs_d;
      bsy_q <= port_busy;
      rne_q <= (rx_lvl != '0);
      tnf_q <= (tx_lvl < FULL_L);
    end
  end

  AST_RFS_OFF: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> !rfs_q);                                        // R9
  AST_TFS_OFF: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> !tfs_q);                                        // R10
  AST_TNF_FULL: assert property (@(posedge clk) disable iff (rst)
    (tx_lvl >= FULL_L) |=> !tnf_q);                              // R11
  AST_RNE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rx_lvl == '0) |=> (!rne_q && rfl_q == 4'hF));               // R8

endmodule

// File: rtl/sport_stat_irq.sv
module sport_stat_irq
  import sport_stat_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int LVL_W  = $clog2(DEPTH + 1),
  parameter int BCNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              port_busy,
  input  logic [LVL_W-1:0]  tx_lvl,
  input  logic [LVL_W-1:0]  rx_lvl,
  input  logic [LVL_W-1:0]  tx_thr,
  input  logic [LVL_W-1:0]  rx_thr,
  input  logic              tx_pop,
  input  logic              rx_push,
  input  logic              fsync,
  input  logic [BCNT_W-1:0] bit_cnt,
  input  logic              dma_eoc,
  input  logic              rx_tmo,
  input  logic              trail_evt,
  input  logic              frm_match,
  input  logic [8:0]        irq_en,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       stat_word,
  output logic              irq
);

  logic [NUM_STK-1:0] ev_set, ev_clr, stk_q, stk_nxt;
  logic               rfs_d, tfs_d, rfs_q, tfs_q, bsy_q, rne_q, tnf_q;
  logic [3:0]         rfl_q, tfl_q;
  logic [NUM_IRQ-1:0] src_nxt;
  logic               irq_q;

  sport_evt_qual #(.DEPTH(DEPTH), .LVL_W(LVL_W), .BCNT_W(BCNT_W)) u_qual (
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_pop(tx_pop), .rx_push(rx_push),
    .fsync(fsync), .bit_cnt(bit_cnt), .dma_eoc(dma_eoc), .rx_tmo(rx_tmo),
    .trail_evt(trail_evt), .frm_match(frm_match), .ev_set(ev_set)
  );

  for (genvar i = 0; i < NUM_STK; i++) begin : g_clr
    assign ev_clr[i] = wr_en && wr_data[stk_pos(i)];
  end

  sport_sticky_bank #(.N(NUM_STK)) u_stk (
    .clk(clk), .rst(rst), .set_i(ev_set), .clr_i(ev_clr), .flag_q(stk_q)
  );

  sport_level_view #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_lvl (
    .clk(clk), .rst(rst), .port_en(port_en), .port_busy(port_busy),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .rfs_d(rfs_d), .tfs_d(tfs_d), .rfl_q(rfl_q), .tfl_q(tfl_q),
    .rfs_q(rfs_q), .tfs_q(tfs_q), .bsy_q(bsy_q), .rne_q(rne_q), .tnf_q(tnf_q)
  );

  // interrupt is registered from the values the status word takes next
  always_comb begin
    stk_nxt = ev_set | (stk_q & ~ev_clr);
    src_nxt = {tfs_d, rfs_d, stk_nxt};
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(src_nxt & irq_en);
  end

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < NUM_STK; i++) stat_word[stk_pos(i)] = stk_q[i];
    stat_word[15:12]   = rfl_q;
    stat_word[11:8]    = tfl_q;
    stat_word[POS_RFS] = rfs_q;
    stat_word[POS_TFS] = tfs_q;
    stat_word[4]       = bsy_q;
    stat_word[3]       = rne_q;
    stat_word[2]       = tnf_q;
  end

  assign irq = irq_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stat_word & RSVD_MASK) == 32'h0);                           // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (irq_en == '0) |=> !irq);                                    // R12
  AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
    irq |-> (stat_word & 32'h01BC_00E0) != 32'h0);               // R12

endmodule

// File: tb/sim_sport_stat_irq.sv
module sim_sport_stat_irq;

  localparam int DEPTH  = 32;
  localparam int LVL_W  = 6;
  localparam int BCNT_W = 5;
  localparam logic [31:0] STK_M = 32'h01BC_0080;

  logic clk = 0, rst = 1;
  logic port_en = 0, port_busy = 0;
  logic [LVL_W-1:0] tx_lvl = 0, rx_lvl = 0, tx_thr = 0, rx_thr = 0;
  logic tx_pop = 0, rx_push = 0, fsync = 0;
  logic [BCNT_W-1:0] bit_cnt = 0;
  logic dma_eoc = 0, rx_tmo = 0, trail_evt = 0, frm_match = 0;
  logic [8:0] irq_en = 0;
  logic wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] stat_word;
  logic irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_stk = 0, m_word = 32'h0000_F004;
  logic m_irq = 0;

  always #5 clk = ~clk;

  sport_stat_irq #(.DEPTH(DEPTH), .LVL_W(LVL_W), .BCNT_W(BCNT_W)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] set_word();
    logic [31:0] s = 0;
    s[7]  = rx_push && (rx_lvl == LVL_W'(DEPTH));
    s[18] = trail_evt;
    s[19] = rx_tmo;
    s[20] = dma_eoc;
    s[21] = tx_pop && (tx_lvl == 0);
    s[23] = fsync && (bit_cnt != 0);
    s[24] = frm_match;
    return s;
  endfunction

  function automatic logic [31:0] live_word();
    logic [31:0] w = 0;
    int rm1 = int'(rx_lvl) - 1;
    w[15:12] = rm1[3:0];
    w[11:8]  = tx_lvl[3:0];
    w[6] = port_en && (int'(rx_lvl) > int'(rx_thr));
    w[5] = port_en && (int'(tx_lvl) <= int'(tx_thr) + 1);
    w[4] = port_busy;
    w[3] = rx_lvl != 0;
    w[2] = int'(tx_lvl) < DEPTH;
    return w;
  endfunction

  function automatic logic irq_of(input logic [31:0] w);
    logic [8:0] s = {w[5], w[6], w[24], w[23], w[21], w[20], w[19], w[18], w[7]};
    return |(s & irq_en);
  endfunction

  // one clock: model update at the edge, compare at the falling edge
  task automatic step();
    @(posedge clk);
    m_stk  = (m_stk & ~(wr_en ? (wr_data & STK_M) : 32'h0)) | set_word();
    m_word = m_stk | live_word();
    m_irq  = irq_of(m_word);
    @(negedge clk);
    chk("R2",  stat_word & 32'hFE43_0003, 32'h0);
    chk("R8",  {16'h0, stat_word[15:8], 8'h0}, {16'h0, m_word[15:8], 8'h0});
    chk("R9",  32'(stat_word[6]), 32'(m_word[6]));
    chk("R10", 32'(stat_word[5]), 32'(m_word[5]));
    chk("R11", 32'(stat_word[4:2]), 32'(m_word[4:2]));
    chk("R3",  32'(stat_word[23]), 32'(m_word[23]));
    chk("R4",  32'(stat_word[21]), 32'(m_word[21]));
    chk("R5",  32'(stat_word[7]), 32'(m_word[7]));
    chk("R6",  stat_word & 32'h011C_0000, m_word & 32'h011C_0000);
    chk("R12", 32'(irq), 32'(m_irq));
  endtask

  task automatic quiet();
    tx_pop = 0; rx_push = 0; fsync = 0; dma_eoc = 0; rx_tmo = 0;
    trail_evt = 0; frm_match = 0; wr_en = 0; wr_data = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1", stat_word, 32'h0000_F004);
    chk("R1", 32'(irq), 32'h0);
    rst = 0;
    step();
    chk("R1", stat_word, 32'h0000_F004);

    // R3: zero bit count is harmless, nonzero sets
    irq_en = 9'h1FF;
    fsync = 1; bit_cnt = 0; step();
    bit_cnt = 3; step(); quiet();
    chk("R3", 32'(stat_word[23]), 32'h1);
    // R7: write 0 keeps, set beats clear, lone clear clears
    wr_en = 1; wr_data = 32'h0; step();
    chk("R7", 32'(stat_word[23]), 32'h1);
    wr_data = 32'h0080_0000; fsync = 1; bit_cnt = 1; step(); quiet();
    chk("R7", 32'(stat_word[23]), 32'h1);
    wr_en = 1; wr_data = 32'h0080_0000; step(); quiet();
    chk("R7", 32'(stat_word[23]), 32'h0);
    // R2: writing ones to reserved bits
    wr_en = 1; wr_data = 32'hFFFF_FFFF; step(); quiet();
    // R4 underrun on empty, none on non-empty
    tx_lvl = 1; tx_pop = 1; step();
    tx_lvl = 0; step(); quiet();
    chk("R4", 32'(stat_word[21]), 32'h1);
    // R5 overrun at full, none one below
    rx_lvl = LVL_W'(DEPTH - 1); rx_push = 1; step();
    rx_lvl = LVL_W'(DEPTH); step(); quiet();
    chk("R5", 32'(stat_word[7]), 32'h1);
    // R6 strobes
    dma_eoc = 1; rx_tmo = 1; step(); quiet();
    trail_evt = 1; frm_match = 1; step(); quiet();
    // R10 boundary at threshold plus one, R9 at threshold
    port_en = 1; wr_en = 1; wr_data = 32'hFFFF_FFFF; irq_en = 9'h180;
    tx_thr = 4; tx_lvl = 5; rx_thr = 7; rx_lvl = 7; step(); quiet();
    tx_lvl = 6; rx_lvl = 8; step();
    tx_lvl = 16; rx_lvl = 17; step();
    tx_lvl = 0; rx_lvl = 0; port_en = 0; step();

    for (int k = 0; k < 4000; k++) begin
      port_en   = ($urandom % 4) != 0;
      port_busy = $urandom;
      tx_lvl    = LVL_W'($urandom % (DEPTH + 1));
      rx_lvl    = LVL_W'($urandom % (DEPTH + 1));
      if (($urandom % 6) == 0) tx_lvl = 0;
      if (($urandom % 6) == 0) rx_lvl = LVL_W'(DEPTH);
      tx_thr    = LVL_W'($urandom % DEPTH);
      rx_thr    = LVL_W'($urandom % DEPTH);
      tx_pop    = ($urandom % 4) == 0;
      rx_push   = ($urandom % 4) == 0;
      fsync     = ($urandom % 8) == 0;
      bit_cnt   = BCNT_W'($urandom % 3);
      dma_eoc   = ($urandom % 8) == 0;
      rx_tmo    = ($urandom % 8) == 0;
      trail_evt = ($urandom % 8) == 0;
      frm_match = ($urandom % 8) == 0;
      irq_en    = 9'($urandom);
      wr_en     = ($urandom % 4) == 0;
      wr_data   = $urandom;
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule